// File: doc/BRIEF.md
# Super I/O Configuration Port Unlock Controller

This block is the configuration front end of a legacy Super I/O device on a simple byte-wide I/O bus. It watches two bus addresses: an index port and a data port. A strap input chooses which address pair is used. Until software writes a fixed two-byte password to the index port, configuration registers are locked. While locked, data-port writes change nothing and data-port reads return all ones.

Once the block is unlocked, a write to the index port picks a register number. A following write to the data port updates that register, and a read of the data port returns it. One global register selects a logical device. Each logical device has its own bank with an activate bit and a 16-bit I/O base address. The settings of every device are driven out to downstream decode logic. A base address is only presented while its device is active, so software clears the activate bit, programs the base, then sets the bit again. A one-byte exit key locks the block again.

Top module: `sio_cfg_unlock`

## Requirements
- R1: After reset the block is locked, the index register and device select are 0x00, every device is inactive and every base address is 0x0000.
- R2: Configuration mode is entered only after two consecutive index-port writes of 0xA5; after a single 0xA5 the block is still locked.
- R3: An index-port write of any byte other than 0xA5 while the first key is pending returns the block to the locked idle state, so two new 0xA5 writes are then needed.
- R4: An index-port write of 0xAA in configuration mode leaves configuration mode.
- R5: With strap low the index and data ports are at I/O addresses 0x004E and 0x004F; with strap high they are at 0x002E and 0x002F; accesses to any other address have no effect and read 0xFF.
- R6: While locked, data-port writes change no register, and reads of either port return 0xFF.
- R7: In configuration mode an index-port write stores the register number, a data-port write updates the indexed register, and an index-port read returns the stored register number.
- R8: Register 0x07 holds the logical device number. Per-device registers are accessed in the bank of the selected device. A device number of NUM_LDEV or above selects no bank: its registers read 0x00 and writes to them are dropped.
- R9: In each bank, register 0x30 bit 0 is the activate bit and reads back with bits 7:1 as zero. Register 0x60 holds the base address high byte and 0x61 the low byte. Any other index reads 0x00 and ignores writes.
- R10: Output dev_iobase slice n (bits 16n+15:16n) carries the base address of device n while dev_active[n] is set and 0x0000 otherwise.
- R11: Leaving configuration mode clears the index register to 0x00 and keeps the device select and all bank contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_alt | input | 1 | Selects the alternative port address pair |
| io_addr | input | ADDR_W | I/O bus address |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the cycle of io_rd |
| dev_active | output | NUM_LDEV | Activate bit of each logical device |
| dev_iobase | output | 16*NUM_LDEV | Base address of each device, zero while inactive |

## Verification
The unlock logic is driven with three key patterns: a single 0xA5, two 0xA5 in a row, and 0xA5 then a stray byte then 0xA5. These separate a correct two-step match from a one-step match and from a sequence that fails to restart. Register traffic is sent to an in-range device, to a second device, and to an out-of-range device number, which shows that the bank select routes writes correctly. The activate bit is toggled around base programming to show the gating of the base output. The strap is flipped to show that only the chosen address pair responds.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    localparam logic [7:0] KEY_ENTER   = 8'hA5;
    localparam logic [7:0] KEY_LEAVE   = 8'hAA;

    localparam logic [7:0] REG_DEVSEL  = 8'h07;
    localparam logic [7:0] REG_ACT     = 8'h30;
    localparam logic [7:0] REG_BASE_HI = 8'h60;
    localparam logic [7:0] REG_BASE_LO = 8'h61;

    localparam logic [7:0] READ_IDLE   = 8'hFF;

    typedef enum logic [1:0] {
        LK_IDLE   = 2'd0,
        LK_HALF   = 2'd1,
        LK_OPEN   = 2'd2
    } lock_state_e;

    typedef struct packed {
        logic [7:0] index;
        logic [7:0] devsel;
    } front_state_t;

    typedef struct packed {
        logic        act;
        logic [7:0]  base_hi;
        logic [7:0]  base_lo;
    } bank_state_t;

endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode #(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] PAIR_DEF = 16'h004E,
    parameter logic [15:0] PAIR_ALT = 16'h002E
) (
    input  logic              strap_alt,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              idx_hit,
    output logic              dat_hit
);
    localparam logic [ADDR_W-1:0] IDX_DEF = ADDR_W'(PAIR_DEF);
    localparam logic [ADDR_W-1:0] IDX_ALT = ADDR_W'(PAIR_ALT);

    logic [ADDR_W-1:0] idx_addr;
    logic [ADDR_W-1:0] dat_addr;

    always_comb begin
        idx_addr = strap_alt ? IDX_ALT : IDX_DEF;
        dat_addr = idx_addr + ADDR_W'(1);
        idx_hit  = (io_addr == idx_addr);
        dat_hit  = (io_addr == dat_addr);
    end

endmodule

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       cfg_mode
);
    lock_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (idx_wr) begin
            unique case (state_q)
                LK_IDLE: state_d = (wdata == KEY_ENTER) ? LK_HALF : LK_IDLE;
                LK_HALF: state_d = (wdata == KEY_ENTER) ? LK_OPEN : LK_IDLE;
                LK_OPEN: state_d = (wdata == KEY_LEAVE) ? LK_IDLE : LK_OPEN;
                default: state_d = LK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_IDLE;
        else        state_q <= state_d;
    end

    assign cfg_mode = (state_q == LK_OPEN);

    // Opening needs a key byte in the cycle before and a half-open state.
    assert_open_needs_keys_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_mode) |-> ($past(idx_wr) && $past(wdata) == KEY_ENTER && $past(state_q) == LK_HALF));

    assert_half_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_IDLE && !(idx_wr && wdata == KEY_ENTER)) |=> state_q != LK_OPEN);

    assert_stray_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_HALF && idx_wr && wdata != KEY_ENTER) |=> state_q == LK_IDLE);

    assert_leave_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && idx_wr && wdata == KEY_LEAVE) |=> !cfg_mode);

endmodule

// File: rtl/sio_ldev_bank.sv
module sio_ldev_bank
    import sio_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  index,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        active,
    output logic [15:0] base
);
    bank_state_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            unique case (index)
                REG_ACT:     bank_d.act     = wdata[0];
                REG_BASE_HI: bank_d.base_hi = wdata;
                REG_BASE_LO: bank_d.base_lo = wdata;
                default:     bank_d         = bank_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        unique case (index)
            REG_ACT:     rdata = {7'b0, bank_q.act};
            REG_BASE_HI: rdata = bank_q.base_hi;
            REG_BASE_LO: rdata = bank_q.base_lo;
            default:     rdata = 8'h00;
        endcase
    end

    assign active = bank_q.act;
    assign base   = {bank_q.base_hi, bank_q.base_lo};

    // Without a qualified write the bank holds still (R6, R8).
    assert_bank_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank_q));

    assert_act_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && index == REG_ACT) |=> active == $past(wdata[0]));

endmodule

// File: rtl/sio_cfg_unlock.sv
module sio_cfg_unlock
    import sio_cfg_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          NUM_LDEV = 4,
    parameter logic [15:0] PAIR_DEF = 16'h004E,
    parameter logic [15:0] PAIR_ALT = 16'h002E
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   strap_alt,
    input  logic [ADDR_W-1:0]      io_addr,
    input  logic                   io_wr,
    input  logic                   io_rd,
    input  logic [7:0]             io_wdata,
    output logic [7:0]             io_rdata,
    output logic [NUM_LDEV-1:0]    dev_active,
    output logic [16*NUM_LDEV-1:0] dev_iobase
);
    localparam int         SEL_W    = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1;
    localparam logic [7:0] LDEV_LIM = 8'(NUM_LDEV);

    logic idx_hit, dat_hit, cfg_mode;
    logic idx_wr, dat_wr;
    logic sel_ok;
    logic [SEL_W-1:0] sel;
    logic [7:0]  bank_rd   [NUM_LDEV];
    logic [15:0] bank_base [NUM_LDEV];

    front_state_t fs_d, fs_q;

    sio_port_decode #(
        .ADDR_W   (ADDR_W),
        .PAIR_DEF (PAIR_DEF),
        .PAIR_ALT (PAIR_ALT)
    ) u_dec (
        .strap_alt (strap_alt),
        .io_addr   (io_addr),
        .idx_hit   (idx_hit),
        .dat_hit   (dat_hit)
    );

    assign idx_wr = io_wr && idx_hit;
    assign dat_wr = io_wr && dat_hit;

    sio_key_fsm u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wdata    (io_wdata),
        .cfg_mode (cfg_mode)
    );

    assign sel_ok = (fs_q.devsel < LDEV_LIM);
    assign sel    = fs_q.devsel[SEL_W-1:0];

    // Front registers: index and device select.
    always_comb begin
        fs_d = fs_q;
        if (cfg_mode && idx_wr) begin
            if (io_wdata == KEY_LEAVE) fs_d.index = 8'h00;
            else                       fs_d.index = io_wdata;
        end
        if (cfg_mode && dat_wr && fs_q.index == REG_DEVSEL)
            fs_d.devsel = io_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    generate
        for (genvar g = 0; g < NUM_LDEV; g++) begin : g_bank
            logic bank_we;
            assign bank_we = cfg_mode && dat_wr && sel_ok
                             && (fs_q.devsel == 8'(g))
                             && (fs_q.index != REG_DEVSEL);

            sio_ldev_bank u_bank (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (bank_we),
                .index  (fs_q.index),
                .wdata  (io_wdata),
                .rdata  (bank_rd[g]),
                .active (dev_active[g]),
                .base   (bank_base[g])
            );

            assign dev_iobase[16*g +: 16] = dev_active[g] ? bank_base[g] : 16'h0000;

            assert_base_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(dev_active[g]) |-> dev_iobase[16*g +: 16] == 16'h0000);
        end
    endgenerate

    // Read path.
    always_comb begin
        io_rdata = READ_IDLE;
        if (io_rd && cfg_mode && idx_hit) begin
            io_rdata = fs_q.index;
        end else if (io_rd && cfg_mode && dat_hit) begin
            if (fs_q.index == REG_DEVSEL) io_rdata = fs_q.devsel;
            else if (sel_ok)              io_rdata = bank_rd[sel];
            else                          io_rdata = 8'h00;
        end
    end

    assert_locked_no_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && dat_wr) |=> $stable(fs_q.devsel));

    assert_leave_clears_index_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_mode) |-> (fs_q.index == 8'h00 && $stable(fs_q.devsel)));

    assert_locked_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && io_rd && (idx_hit || dat_hit)) |-> io_rdata == READ_IDLE);

endmodule

// File: tb/sim_sio_cfg_unlock.sv
module sim_sio_cfg_unlock;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 4;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        strap_alt = 0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 0;
    logic        io_rd = 0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [NL-1:0]    dev_active;
    logic [16*NL-1:0] dev_iobase;

    int checks = 0;
    int fails  = 0;
    logic [15:0] pidx = 16'h004E;
    logic [15:0] pdat = 16'h004F;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_cfg_unlock #(.NUM_LDEV(NL)) u0 (
        .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata),
        .dev_active(dev_active), .dev_iobase(dev_iobase)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1;
        @(negedge clk);
        io_wr = 0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 0;
    endtask

    task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
        wr(pidx, i); wr(pdat, d);
    endtask

    task automatic reg_rd(input logic [7:0] i, output logic [7:0] d);
        wr(pidx, i); rd(pdat, d);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 active", 64'(dev_active), 64'h0);
        check("R1 iobase", 64'(dev_iobase), 64'h0);
        rd(pdat, d); check("R1 R6 locked data read", 64'(d), 64'hFF);
        rd(pidx, d); check("R6 locked index read", 64'(d), 64'hFF);
    endtask

    task automatic t_unlock();
        logic [7:0] d;
        wr(pidx, 8'hA5);
        rd(pdat, d); check("R2 one key still locked", 64'(d), 64'hFF);
        wr(pidx, 8'hA5);
        rd(pidx, d); check("R2 R7 open index reads 00", 64'(d), 64'h00);
        rd(pdat, d); check("R1 devsel 0", 64'(d), 64'h00);
    endtask

    task automatic t_abort();
        logic [7:0] d;
        wr(pidx, 8'hAA);
        rd(pdat, d); check("R4 leave key locks", 64'(d), 64'hFF);
        wr(pidx, 8'hA5); wr(pidx, 8'h55); wr(pidx, 8'hA5);
        rd(pidx, d); check("R3 stray byte restarts", 64'(d), 64'hFF);
        wr(pidx, 8'hA5);
        rd(pidx, d); check("R3 second key after restart opens", 64'(d), 64'h00);
    endtask

    task automatic t_program();
        logic [7:0] d;
        reg_wr(8'h07, 8'h02);
        reg_wr(8'h30, 8'h00);
        reg_wr(8'h60, 8'h03);
        reg_wr(8'h61, 8'hF8);
        check("R10 base hidden while inactive", 64'(dev_iobase), 64'h0);
        reg_wr(8'h30, 8'h01);
        check("R9 activate bit", 64'(dev_active), 64'h4);
        check("R10 base shown", 64'(dev_iobase), 64'h0000_03F8_0000_0000);
        reg_rd(8'h60, d); check("R7 R9 high byte", 64'(d), 64'h03);
        reg_rd(8'h61, d); check("R9 low byte", 64'(d), 64'hF8);
        reg_wr(8'h30, 8'hFF);
        reg_rd(8'h30, d); check("R9 activate reads bit0 only", 64'(d), 64'h01);
        reg_wr(8'h31, 8'h5A);
        reg_rd(8'h31, d); check("R9 unimplemented index", 64'(d), 64'h00);
        wr(pidx, 8'h61); rd(pidx, d); check("R7 index read back", 64'(d), 64'h61);
    endtask

    task automatic t_devsel();
        logic [7:0] d;
        reg_wr(8'h07, 8'h01);
        reg_rd(8'h60, d); check("R8 other bank empty", 64'(d), 64'h00);
        reg_wr(8'h60, 8'h02); reg_wr(8'h61, 8'h78);
        check("R8 R10 device1 inactive", 64'(dev_iobase[31:16]), 64'h0);
        reg_rd(8'h07, d); check("R8 devsel read", 64'(d), 64'h01);
        reg_wr(8'h07, 8'h07);
        reg_wr(8'h60, 8'hAA);
        reg_rd(8'h60, d); check("R8 out-of-range reads 00", 64'(d), 64'h00);
        reg_wr(8'h07, 8'h02);
        reg_rd(8'h60, d); check("R8 device2 untouched", 64'(d), 64'h03);
        reg_wr(8'h07, 8'h01);
        reg_rd(8'h61, d); check("R8 device1 low byte kept", 64'(d), 64'h78);
        reg_wr(8'h30, 8'h01);
        check("R10 two devices", 64'(dev_iobase), 64'h0000_03F8_0278_0000);
        reg_wr(8'h30, 8'h00);
        reg_wr(8'h07, 8'h02);
    endtask

    task automatic t_exit();
        logic [7:0] d;
        wr(pidx, 8'h30);
        wr(pidx, 8'hAA);
        wr(pdat, 8'h00);
        check("R6 locked write ignored", 64'(dev_active), 64'h4);
        rd(pidx, d); check("R6 locked index read", 64'(d), 64'hFF);
        wr(pidx, 8'hA5); wr(pidx, 8'hA5);
        rd(pidx, d); check("R11 index cleared", 64'(d), 64'h00);
        reg_rd(8'h07, d); check("R11 devsel kept", 64'(d), 64'h02);
        reg_rd(8'h30, d); check("R11 bank kept", 64'(d), 64'h01);
        wr(pidx, 8'hAA);
    endtask

    task automatic t_strap();
        logic [7:0] d;
        strap_alt = 1;
        wr(16'h004E, 8'hA5); wr(16'h004E, 8'hA5);
        rd(16'h002E, d); check("R5 old pair ignored under strap", 64'(d), 64'hFF);
        pidx = 16'h002E; pdat = 16'h002F;
        wr(pidx, 8'hA5); wr(pidx, 8'hA5);
        rd(pidx, d); check("R5 alt pair opens", 64'(d), 64'h00);
        rd(16'h004F, d); check("R5 unmapped address reads FF", 64'(d), 64'hFF);
        wr(16'h004E, 8'hAA);
        rd(pidx, d); check("R5 leave key on wrong port ignored", 64'(d), 64'h00);
        reg_rd(8'h60, d); check("R5 bank via alt pair", 64'(d), 64'h03);
        wr(16'h0080, 8'h00);
        check("R5 stray address no effect", 64'(dev_active), 64'h4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_unlock();
        t_abort();
        t_program();
        t_devsel();
        t_exit();
        t_strap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule